// File: doc/BRIEF.md
# Binary Search Tree Insertion Engine

The engine takes a stream of unsigned 14-bit items and builds a binary search tree in a single-port RAM that sits outside the block. Every tree node fills one RAM word. The word packs the node's value together with the addresses of its left and right children. For each item it accepts, the engine starts at the root and walks down the tree, one RAM read per level. At each node it compares the item with the node's value and picks a child. When the chosen child is absent, the engine writes the new node into the next free word and then rewrites the parent word so that it points to the new node.

Items larger than 9999 are taken off the input stream and thrown away. Nodes are placed in arrival order, so the root always sits at address 0. The all-ones address marks an absent child and is never allocated. The block therefore holds at most 2047 nodes; when that limit is reached it raises a full flag and stops accepting input. A one-cycle done pulse marks the end of each insertion.

Top module: `bst_insert`

## Requirements
- R1: A node word is {value[35:22], left[21:11], right[10:0]}. Address 11'h7FF means "no child", and every newly written node has both pointer fields set to 11'h7FF.
- R2: The first accepted item is written at address 0. rootAddr reads 11'h7FF while the tree is empty and 0 once it is not.
- R3: While walking, an item smaller than the node's value goes to the left child, and an item equal to or larger than it goes to the right child. Inserting 19,22,17,20,35,11,21,31,15,7 gives root 19 with children 17 and 22, 11 to the left of 17, 7 and 15 under 11, 20 and 35 under 22, 21 to the right of 20, and 31 to the left of 35.
- R4: An item above 9999 is accepted when inReady is high and is then dropped: no RAM write, no done pulse, and inReady is high again on the next cycle.
- R5: Stored items take consecutive addresses 0,1,2,… in the order they arrive.
- R6: Once 2047 nodes are stored, full is high and inReady is low, and no further RAM write happens.
- R7: When a new node is linked in, the parent word is rewritten with only the selected child field changed to the new node's address.
- R8: Each tree level costs one read cycle and one compare cycle. For an item that visits d existing nodes, insDone is high 2d+2 cycles after the accepting clock edge. For the first item of an empty tree it is high 1 cycle after that edge.
- R9: insDone is a single-cycle pulse, issued once for each stored item.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset, empties the tree |
| inValid | input | 1 | Input item valid |
| inData | input | 14 | Input item |
| inReady | output | 1 | Engine can accept an item |
| memAddr | output | 11 | RAM address |
| memWe | output | 1 | RAM write enable |
| memWdata | output | 36 | RAM write word |
| memRdata | input | 36 | RAM read word, valid one cycle after its address |
| rootAddr | output | 11 | Root node address, or 11'h7FF when empty |
| insDone | output | 1 | Insertion finished |
| full | output | 1 | Node storage exhausted |

## Verification
The example sequence of ten items checks a known tree shape node by node. It separates a correct left/right choice from a swapped one, and correct parent patching from a patch that clobbers the sibling field. Values above the limit, including the largest 14-bit code, show that the drop filter sits on the right boundary. A repeated value shows that ties descend to the right. A seeded random stream then fills the memory to capacity with drop values mixed in. It compares every stored word against a bench model, checks the done latency of every insertion against the depth the model predicts, and shows that the block stalls at exactly 2047 nodes.

// File: rtl/bst_pkg.sv
package bst_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_CMP, S_WNEW, S_WPAR
  } stateT;

  typedef struct packed {
    logic loadItem;
    logic stepChild;
    logic latchParent;
    logic writeNew;
    logic writePar;
    logic bumpFree;
  } ctrlT;
endpackage

// File: rtl/bst_datapath.sv
module bst_datapath
  import bst_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int ADDR_W = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  ctrlT                        ctl,
  input  logic [DATA_W-1:0]           inData,
  input  logic [DATA_W+2*ADDR_W-1:0]  memRdata,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        memWe,
  output logic [DATA_W+2*ADDR_W-1:0]  memWdata,
  output logic                        treeEmpty,
  output logic                        full,
  output logic                        childNull,
  output logic [ADDR_W-1:0]           rootAddr
);
  localparam int WORD_W = DATA_W + 2*ADDR_W;
  localparam logic [ADDR_W-1:0] NULL_A = '1;

  logic [DATA_W-1:0] itemQ;
  logic [ADDR_W-1:0] curQ, freeQ;
  logic [WORD_W-1:0] parWordQ;
  logic              dirRightQ;

  logic [DATA_W-1:0] rdVal;
  logic [ADDR_W-1:0] rdLeft, rdRight, child;
  logic              goRight;

  assign rdVal   = memRdata[WORD_W-1 -: DATA_W];
  assign rdLeft  = memRdata[2*ADDR_W-1 -: ADDR_W];
  assign rdRight = memRdata[ADDR_W-1:0];
  assign goRight = itemQ >= rdVal;
  assign child   = goRight ? rdRight : rdLeft;
  assign childNull = child == NULL_A;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      itemQ     <= '0;
      curQ      <= '0;
      freeQ     <= '0;
      parWordQ  <= '0;
      dirRightQ <= 1'b0;
    end else begin
      if (ctl.loadItem) begin
        itemQ <= inData;
        curQ  <= '0;
      end
      if (ctl.stepChild) curQ <= child;
      if (ctl.latchParent) begin
        parWordQ  <= memRdata;
        dirRightQ <= goRight;
      end
      if (ctl.bumpFree) freeQ <= freeQ + 1'b1;
    end
  end

  logic [WORD_W-1:0] patched;
  always_comb begin
    patched = parWordQ;
    if (dirRightQ) patched[ADDR_W-1:0] = freeQ;
    else           patched[2*ADDR_W-1 -: ADDR_W] = freeQ;
  end

  assign memWe    = ctl.writeNew | ctl.writePar;
  assign memAddr  = ctl.writeNew ? freeQ : curQ;
  assign memWdata = ctl.writeNew ? {itemQ, NULL_A, NULL_A} : patched;

  assign treeEmpty = freeQ == '0;
  assign full      = freeQ == NULL_A;
  assign rootAddr  = treeEmpty ? NULL_A : '0;

  // R5: the allocation pointer only ever moves forward by one
  assert_free_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freeQ) |-> freeQ == ADDR_W'($past(freeQ) + 1'b1));

  // R1/R6: the null address is never written
  assert_no_null_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> memAddr != NULL_A);
endmodule

// File: rtl/bst_control.sv
module bst_control
  import bst_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int MAX_VAL = 9999
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              treeEmpty,
  input  logic              full,
  input  logic              childNull,
  output logic              inReady,
  output logic              insDone,
  output ctrlT              ctl
);
  localparam logic [DATA_W-1:0] MAX_V = DATA_W'(MAX_VAL);

  stateT state, stateNx;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= stateNx;
  end

  always_comb begin
    stateNx = state;
    ctl     = '0;
    insDone = 1'b0;
    inReady = 1'b0;
    unique case (state)
      S_IDLE: begin
        inReady = !full;
        if (inValid && !full && inData <= MAX_V) begin
          ctl.loadItem = 1'b1;
          stateNx = treeEmpty ? S_WNEW : S_READ;
        end
      end
      S_READ: stateNx = S_CMP;
      S_CMP: begin
        ctl.latchParent = 1'b1;
        if (childNull) stateNx = S_WNEW;
        else begin
          ctl.stepChild = 1'b1;
          stateNx = S_READ;
        end
      end
      S_WNEW: begin
        ctl.writeNew = 1'b1;
        if (treeEmpty) begin
          ctl.bumpFree = 1'b1;
          insDone = 1'b1;
          stateNx = S_IDLE;
        end else stateNx = S_WPAR;
      end
      S_WPAR: begin
        ctl.writePar = 1'b1;
        ctl.bumpFree = 1'b1;
        insDone = 1'b1;
        stateNx = S_IDLE;
      end
      default: stateNx = S_IDLE;
    endcase
  end

  // R8: every read cycle is followed by its compare cycle
  assert_read_cmp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_READ |=> state == S_CMP);

  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    insDone |=> !insDone);
endmodule

// File: rtl/bst_insert.sv
module bst_insert
  import bst_pkg::*;
#(
  parameter int DATA_W  = 14,
  parameter int ADDR_W  = 11,
  parameter int MAX_VAL = 9999
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        inValid,
  input  logic [DATA_W-1:0]           inData,
  output logic                        inReady,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        memWe,
  output logic [DATA_W+2*ADDR_W-1:0]  memWdata,
  input  logic [DATA_W+2*ADDR_W-1:0]  memRdata,
  output logic [ADDR_W-1:0]           rootAddr,
  output logic                        insDone,
  output logic                        full
);
  ctrlT ctl;
  logic treeEmpty, childNull;

  bst_control #(.DATA_W(DATA_W), .MAX_VAL(MAX_VAL)) u_ctl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData),
    .treeEmpty(treeEmpty), .full(full), .childNull(childNull),
    .inReady(inReady), .insDone(insDone), .ctl(ctl)
  );

  bst_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .inData(inData),
    .memRdata(memRdata), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .treeEmpty(treeEmpty), .full(full),
    .childNull(childNull), .rootAddr(rootAddr)
  );

  // R6: a full engine never offers to accept
  assert_full_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !inReady);

  // R4: an over-range item causes no write and leaves the engine ready
  assert_drop_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady && inData > DATA_W'(MAX_VAL)) |=> (!memWe && inReady));
endmodule

// File: tb/bst_insert_tb.sv
module bst_insert_tb;
  localparam int NULLV = 2047;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [13:0] inData = '0;
  logic        inReady, memWe, insDone, full;
  logic [10:0] memAddr, rootAddr;
  logic [35:0] memWdata, memRdata;

  always #10 clk = ~clk;

  bst_insert u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData),
    .inReady(inReady), .memAddr(memAddr), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .rootAddr(rootAddr),
    .insDone(insDone), .full(full)
  );

  logic [35:0] mem [2048];
  always_ff @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  int wrCount = 0;
  int doneCount = 0;
  always @(negedge clk) begin
    if (memWe) wrCount++;
    if (insDone) doneCount++;
  end

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bench model of the tree
  int refVal [2048];
  int refL [2048];
  int refR [2048];
  int refN = 0;

  function automatic int refInsert(input int v);
    int cur, d;
    if (refN == 0) begin
      refVal[0] = v; refL[0] = NULLV; refR[0] = NULLV; refN = 1;
      return 0;
    end
    cur = 0; d = 0;
    forever begin
      d++;
      if (v < refVal[cur]) begin
        if (refL[cur] == NULLV) begin refL[cur] = refN; break; end
        cur = refL[cur];
      end else begin
        if (refR[cur] == NULLV) begin refR[cur] = refN; break; end
        cur = refR[cur];
      end
    end
    refVal[refN] = v; refL[refN] = NULLV; refR[refN] = NULLV; refN++;
    return d;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; inValid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    refN = 0;
  endtask

  // send one item, check latency (R8) or drop behaviour (R4)
  task automatic sendItem(input int v);
    int expLat, cyc, w0, d0;
    bit wasEmpty;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inData = 14'(v);
    w0 = wrCount; d0 = doneCount;
    wasEmpty = (refN == 0);
    @(negedge clk);
    inValid = 1'b0;
    if (v > 9999) begin
      chk(inReady == 1'b1, "R4 ready after drop", int'(inReady), 1);
      repeat (5) @(negedge clk);
      chk(wrCount == w0 && doneCount == d0, "R4 no write/done on drop",
          wrCount - w0, 0);
      return;
    end
    expLat = wasEmpty ? 1 : 2 * refInsert(v) + 2;
    if (wasEmpty) void'(refInsert(v));
    cyc = 1;
    while (!insDone && cyc < 200) begin @(negedge clk); cyc++; end
    chk(cyc == expLat, "R8 done latency", cyc, expLat);
    @(negedge clk);
    chk(!insDone, "R9 single pulse", int'(insDone), 0);
  endtask

  task automatic compareTree(input string tag);
    for (int i = 0; i < refN; i++) begin
      logic [35:0] e;
      e = {14'(refVal[i]), 11'(refL[i]), 11'(refR[i])};
      chk(mem[i] === e, tag, int'(mem[i][35:22]), refVal[i]);
    end
  endtask

  initial begin
    int ex [10] = '{19, 22, 17, 20, 35, 11, 21, 31, 15, 7};
    int w0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    doReset();
    @(negedge clk);
    chk(inReady == 1'b1, "reset inReady", int'(inReady), 1);
    chk(rootAddr == 11'h7FF, "R2 empty root", int'(rootAddr), NULLV);
    chk(!full && !insDone, "reset full/done", int'(full), 0);

    // directed example
    for (int i = 0; i < 10; i++) sendItem(ex[i]);
    chk(rootAddr == 11'd0, "R2 root at 0", int'(rootAddr), 0);
    chk(mem[0] === {14'd19, 11'd2, 11'd1}, "R3 root 19 children 17/22",
        int'(mem[0][21:11]), 2);
    chk(mem[5] === {14'd11, 11'd9, 11'd8}, "R3 node 11 children 7/15",
        int'(mem[5][21:0]), 9 * 2048 + 8);
    chk(mem[3] === {14'd20, 11'h7FF, 11'd6}, "R7 node 20 right 21",
        int'(mem[3][10:0]), 6);
    chk(mem[9] === {14'd7, 11'h7FF, 11'h7FF}, "R1 leaf pointers null",
        int'(mem[9][21:0]), 22'h3FFFFF);
    compareTree("R5 directed tree");

    // drops at the boundary and above
    sendItem(10000);
    sendItem(16383);
    // boundary value accepted, then a tie descends right
    sendItem(9999);
    sendItem(19);
    chk(mem[3][21:11] == 11'd11, "R3 tie goes right then left", int'(mem[3][21:11]), 11);
    compareTree("R7 after ties");

    // random fill to capacity
    doReset();
    while (refN < 2047) begin
      if ($urandom_range(7) == 0) sendItem(int'($urandom_range(16383, 10000)));
      else sendItem(int'($urandom_range(9999)));
    end
    @(negedge clk);
    chk(full == 1'b1, "R6 full raised", int'(full), 1);
    chk(inReady == 1'b0, "R6 ready low", int'(inReady), 0);
    w0 = wrCount;
    inValid = 1'b1; inData = 14'd5;
    repeat (6) @(negedge clk);
    inValid = 1'b0;
    chk(wrCount == w0, "R6 no write when full", wrCount - w0, 0);
    compareTree("R5 random tree");

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule